// File: doc/BRIEF.md
# Acquisition Start and Status Controller

This block sits between a host processor and a sampled acquisition front end. The host programs a start mode and a control word over a small 16-bit word-addressed bus. It then starts a capture, either by writing to a strobe address or by letting a rising edge on an external trigger pin do so. The block drives an acquire-enable level to the sampler. In the delayed mode, that level is held back until a fixed number of sample ticks has passed after the start, so that data taken just after a sampling-clock change is discarded.

The block also gathers the events reported by the FIFO, the DMA engine and the stop logic into a status word. Overflow, end of acquisition and DMA terminal count are sticky flags. Each sticky flag is cleared by a write to its own strobe address. An interrupt line is raised while any enabled source is active. The FIFO storage and the DMA engine are outside this block. The block drives a one-cycle clear pulse toward the FIFO and two control levels toward the DMA engine. All inputs are assumed synchronous to `clk`.

Top module: `acqc_ctrl`

## Requirements
- R1: After reset, acq_en, irq, fifo_clr, dma_en and dma_demand are 0. The trigger register (word 0), the control register (word 5) and every status bit except bits 0, 5 and 9:8 read 0.
- R2: When trigger register bits [1:0] = 2, a write of any data to word 1 (software start) makes acq_en 1 from the cycle after the write.
- R3: When trigger register bits [1:0] = 3, a start loads a delay of DELAY_TICKS (default 72) sample ticks. acq_en rises in the cycle after the sample_tick that brings the count to zero. A tick in the same cycle as the start is not counted.
- R4: When trigger register bit 4 is 1, a rising edge on ext_trig acts as a start. When bit 4 is 0, ext_trig edges have no effect on acq_en.
- R5: When trigger register bits [1:0] are 0 or 1, software and external starts are ignored and acq_en stays 0.
- R6: A write of any data to word 2 (FIFO reset) gives a one-cycle fifo_clr pulse. It also drops acq_en, clears status bits 3 and 4 (even against a same-cycle overflow), and re-arms the start logic.
- R7: A pulse on acq_stop while acq_en is 1 drops acq_en and sets the sticky end-of-acquisition flag (status bit 4). Later starts are ignored until a FIFO reset.
- R8: A pulse on fifo_ovf sets the sticky overflow flag (status bit 3). The flag stays set until a FIFO reset.
- R9: A pulse on dma_tc sets the sticky terminal-count flag (status bit 7). A write of any data to word 3 clears it. If the pulse and the clearing write fall in the same cycle, the flag is left set.
- R10: The status word (word 4, read only) shows fifo_ne live at bit 0 and cal_busy live at bit 5, with BOARD_ID at bits 9:8. Bits 1, 2 and 15:10 read 0.
- R11: Status bit 6 and irq equal the OR of three terms: (terminal-count flag AND control bit 11); (control bit 8 AND the FIFO level term); (control bit 8 AND (overflow OR end-of-acquisition)). The FIFO level term is fifo_half when control bit 9 is 1 and fifo_ne when bit 9 is 0.
- R12: The control register (word 5) keeps only bits 3, 8, 9, 11 and 12 and reads back 0 in all other bits. dma_en follows bit 3 and dma_demand follows bit 12. The trigger register (word 0) keeps only bits [1:0] and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| sample_tick | input | 1 | One pulse per sample period |
| ext_trig | input | 1 | External start trigger level |
| acq_stop | input | 1 | End-of-acquisition pulse from the stop logic |
| fifo_ne | input | 1 | FIFO not empty |
| fifo_half | input | 1 | FIFO half full |
| fifo_ovf | input | 1 | FIFO overflow event pulse |
| cal_busy | input | 1 | Offset calibration in progress |
| dma_tc | input | 1 | DMA terminal-count pulse |
| acq_en | output | 1 | Acquire enable to the sampler |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |
| dma_en | output | 1 | DMA enable level |
| dma_demand | output | 1 | Demand-mode DMA select |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can coincide are the setting of the terminal-count flag by a dma_tc pulse and the host write that clears the same flag. A second such pair is a fifo_ovf pulse arriving in the same cycle as a FIFO-reset write. The bench drives both inputs on the same falling edge, so that they meet at one rising edge. It then reads the status word. The terminal-count flag must still be set (set wins), while the overflow flag must be clear (reset wins). A later clearing write with no pulse must then drop the terminal-count flag.

// File: rtl/acqc_pkg.sv
package acqc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned WORD_W = 16;

  localparam logic [ADDR_W-1:0] A_TRIG  = 3'd0;
  localparam logic [ADDR_W-1:0] A_START = 3'd1;
  localparam logic [ADDR_W-1:0] A_FCLR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TCCLR = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd5;

  // start modes in trigger bits [1:0]
  localparam logic [1:0] MODE_NOW   = 2'd2;
  localparam logic [1:0] MODE_DELAY = 2'd3;

  // control register bit positions
  localparam int unsigned C_DMA_EN  = 3;
  localparam int unsigned C_FIFO_IE = 8;
  localparam int unsigned C_HALF_SEL = 9;
  localparam int unsigned C_TC_IE   = 11;
  localparam int unsigned C_DEMAND  = 12;

  // status word bit positions
  localparam int unsigned S_NE    = 0;
  localparam int unsigned S_OVF   = 3;
  localparam int unsigned S_EOA   = 4;
  localparam int unsigned S_CAL   = 5;
  localparam int unsigned S_PEND  = 6;
  localparam int unsigned S_TC    = 7;
  localparam int unsigned S_ID_LO = 8;

  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic dma_en;
    logic fifo_ie;
    logic half_sel;
    logic tc_ie;
    logic demand;
  } ctrl_t;
endpackage

// File: rtl/acqc_hostregs.sv
module acqc_hostregs
  import acqc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [1:0]        mode,
  output logic              ext_en,
  output ctrl_t             ctrl,
  output logic              start_wr,
  output logic              fclr_wr,
  output logic              tcclr_wr,
  output logic [WORD_W-1:0] trig_rd,
  output logic [WORD_W-1:0] ctrl_rd
);
  logic [1:0] mode_q, mode_d;
  logic       ext_q, ext_d;
  ctrl_t      ctrl_q, ctrl_d;
  logic       unused_wbits;

  assign unused_wbits = ^{wdata[15:13], wdata[10], wdata[7:5], wdata[2]};

  always_comb begin
    mode_d = mode_q;
    ext_d  = ext_q;
    ctrl_d = ctrl_q;
    if (wr && addr == A_TRIG) begin
      mode_d = wdata[1:0];
      ext_d  = wdata[4];
    end
    if (wr && addr == A_CTRL) begin
      ctrl_d.dma_en   = wdata[C_DMA_EN];
      ctrl_d.fifo_ie  = wdata[C_FIFO_IE];
      ctrl_d.half_sel = wdata[C_HALF_SEL];
      ctrl_d.tc_ie    = wdata[C_TC_IE];
      ctrl_d.demand   = wdata[C_DEMAND];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ext_q  <= 1'b0;
      ctrl_q <= '0;
    end else begin
      mode_q <= mode_d;
      ext_q  <= ext_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign mode     = mode_q;
  assign ext_en   = ext_q;
  assign ctrl     = ctrl_q;
  assign start_wr = wr && (addr == A_START);
  assign fclr_wr  = wr && (addr == A_FCLR);
  assign tcclr_wr = wr && (addr == A_TCCLR);

  always_comb begin
    trig_rd = '0;
    trig_rd[1:0] = mode_q;
    trig_rd[4]   = ext_q;
    ctrl_rd = '0;
    ctrl_rd[C_DMA_EN]   = ctrl_q.dma_en;
    ctrl_rd[C_FIFO_IE]  = ctrl_q.fifo_ie;
    ctrl_rd[C_HALF_SEL] = ctrl_q.half_sel;
    ctrl_rd[C_TC_IE]    = ctrl_q.tc_ie;
    ctrl_rd[C_DEMAND]   = ctrl_q.demand;
  end
endmodule

// File: rtl/acqc_start_seq.sv
module acqc_start_seq
  import acqc_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 72
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       ext_en,
  input  logic       sw_start,
  input  logic       ext_trig,
  input  logic       tick,
  input  logic       stop,
  input  logic       fclr,
  output logic       acq_en,
  output logic       eoa_set
);
  localparam int unsigned CNT_W = (DELAY_TICKS < 2) ? 1 : $clog2(DELAY_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DELAY_TICKS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ext_prev_q;
  logic             start_evt;
  logic             cnt_en;

  assign start_evt = sw_start || (ext_en && ext_trig && !ext_prev_q);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    eoa_set = 1'b0;
    if (fclr) begin
      st_d   = ST_ARMED;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (st_q)
        ST_ARMED: if (start_evt) begin
          if (mode == MODE_NOW || (mode == MODE_DELAY && DELAY_TICKS == 0)) begin
            st_d = ST_RUN;
          end else if (mode == MODE_DELAY) begin
            st_d   = ST_WAIT;
            cnt_d  = CNT_LOAD;
            cnt_en = 1'b1;
          end
        end
        ST_WAIT: if (tick) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - CNT_ONE;
          if (cnt_q == CNT_ONE) st_d = ST_RUN;
        end
        ST_RUN: if (stop) begin
          st_d    = ST_DONE;
          eoa_set = 1'b1;
        end
        ST_DONE: st_d = ST_DONE;
        default: st_d = ST_ARMED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_ARMED;
      ext_prev_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      ext_prev_q <= ext_trig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign acq_en = (st_q == ST_RUN);
endmodule

// File: rtl/acqc_flags.sv
module acqc_flags
  import acqc_pkg::*;
#(
  parameter logic [1:0] BOARD_ID = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              ovf_evt,
  input  logic              eoa_evt,
  input  logic              tc_evt,
  input  logic              fclr,
  input  logic              tcclr,
  input  logic              fifo_ne,
  input  logic              fifo_half,
  input  logic              cal_busy,
  output logic [WORD_W-1:0] status,
  output logic              irq
);
  logic ovf_q, ovf_d;
  logic eoa_q, eoa_d;
  logic tc_q, tc_d;
  logic lvl_term, pend;
  logic unused_ctrl;

  assign unused_ctrl = ctrl.dma_en ^ ctrl.demand;

  always_comb begin
    // FIFO reset dominates FIFO-side flags; TC event dominates its clear
    ovf_d = fclr ? 1'b0 : (ovf_q | ovf_evt);
    eoa_d = fclr ? 1'b0 : (eoa_q | eoa_evt);
    tc_d  = tc_evt ? 1'b1 : (tcclr ? 1'b0 : tc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      eoa_q <= 1'b0;
      tc_q  <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      eoa_q <= eoa_d;
      tc_q  <= tc_d;
    end
  end

  assign lvl_term = ctrl.half_sel ? fifo_half : fifo_ne;
  assign pend = (tc_q && ctrl.tc_ie)
             || (ctrl.fifo_ie && (lvl_term || ovf_q || eoa_q));
  assign irq = pend;

  always_comb begin
    status = '0;
    status[S_NE]   = fifo_ne;
    status[S_OVF]  = ovf_q;
    status[S_EOA]  = eoa_q;
    status[S_CAL]  = cal_busy;
    status[S_PEND] = pend;
    status[S_TC]   = tc_q;
    status[S_ID_LO+1:S_ID_LO] = BOARD_ID;
  end
endmodule

// File: rtl/acqc_ctrl.sv
module acqc_ctrl
  import acqc_pkg::*;
#(
  parameter int unsigned DELAY_TICKS = 72,
  parameter logic [1:0]  BOARD_ID    = 2'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [2:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  input  logic        sample_tick,
  input  logic        ext_trig,
  input  logic        acq_stop,
  input  logic        fifo_ne,
  input  logic        fifo_half,
  input  logic        fifo_ovf,
  input  logic        cal_busy,
  input  logic        dma_tc,
  output logic        acq_en,
  output logic        fifo_clr,
  output logic        dma_en,
  output logic        dma_demand,
  output logic        irq
);
  logic [1:0]        mode;
  logic              ext_en;
  ctrl_t             ctrl;
  logic              start_wr, fclr_wr, tcclr_wr;
  logic [WORD_W-1:0] trig_rd, ctrl_rd, stat_w;
  logic              eoa_set;

  acqc_hostregs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mode(mode), .ext_en(ext_en), .ctrl(ctrl), .start_wr(start_wr),
    .fclr_wr(fclr_wr), .tcclr_wr(tcclr_wr), .trig_rd(trig_rd), .ctrl_rd(ctrl_rd)
  );

  acqc_start_seq #(.DELAY_TICKS(DELAY_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(mode), .ext_en(ext_en),
    .sw_start(start_wr), .ext_trig(ext_trig), .tick(sample_tick),
    .stop(acq_stop), .fclr(fclr_wr), .acq_en(acq_en), .eoa_set(eoa_set)
  );

  acqc_flags #(.BOARD_ID(BOARD_ID)) u_flags (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .ovf_evt(fifo_ovf),
    .eoa_evt(eoa_set), .tc_evt(dma_tc), .fclr(fclr_wr), .tcclr(tcclr_wr),
    .fifo_ne(fifo_ne), .fifo_half(fifo_half), .cal_busy(cal_busy),
    .status(stat_w), .irq(irq)
  );

  always_comb begin
    unique case (bus_addr)
      A_TRIG:  bus_rdata = trig_rd;
      A_STAT:  bus_rdata = stat_w;
      A_CTRL:  bus_rdata = ctrl_rd;
      default: bus_rdata = '0;
    endcase
  end

  assign fifo_clr   = fclr_wr;
  assign dma_en     = ctrl.dma_en;
  assign dma_demand = ctrl.demand;
endmodule

// File: rtl/acqc_ctrl_chk.sv
module acqc_ctrl_chk
  import acqc_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [2:0]  bus_addr,
  input logic        sample_tick,
  input logic        ext_trig,
  input logic        dma_tc,
  input logic        acq_en,
  input logic        irq,
  input logic [15:0] stat_w,
  input logic [15:0] ctrl_w
);
  a_r2_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acq_en) |-> $past((bus_wr && bus_addr == A_START) || ext_trig || sample_tick));

  a_r6_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_FCLR) |=> (!acq_en && !stat_w[S_OVF] && !stat_w[S_EOA]));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w[S_OVF] && !(bus_wr && bus_addr == A_FCLR)) |=> stat_w[S_OVF]);

  a_r9_tc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tc |=> stat_w[S_TC]);

  a_r9_tc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_TCCLR && !dma_tc) |=> !stat_w[S_TC]);

  a_r11_tc_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_w[S_TC] && ctrl_w[C_TC_IE]) |-> irq);
endmodule

bind acqc_ctrl acqc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .sample_tick(sample_tick), .ext_trig(ext_trig), .dma_tc(dma_tc),
  .acq_en(acq_en), .irq(irq), .stat_w(stat_w), .ctrl_w(ctrl_rd)
);

// File: tb/acqc_ctrl_tb.sv
module acqc_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        sample_tick = 1'b0, ext_trig = 1'b0, acq_stop = 1'b0;
  logic        fifo_ne = 1'b0, fifo_half = 1'b0, fifo_ovf = 1'b0;
  logic        cal_busy = 1'b0, dma_tc = 1'b0;
  logic        acq_en, fifo_clr, dma_en, dma_demand, irq;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  localparam logic [1:0] BID = 2'd2;

  always #4 clk = ~clk;

  acqc_ctrl #(.DELAY_TICKS(72), .BOARD_ID(BID)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sample_tick(sample_tick),
    .ext_trig(ext_trig), .acq_stop(acq_stop), .fifo_ne(fifo_ne),
    .fifo_half(fifo_half), .fifo_ovf(fifo_ovf), .cal_busy(cal_busy),
    .dma_tc(dma_tc), .acq_en(acq_en), .fifo_clr(fifo_clr), .dma_en(dma_en),
    .dma_demand(dma_demand), .irq(irq)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic tick();
    @(negedge clk); sample_tick = 1'b1;
    @(negedge clk); sample_tick = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); acq_stop = 1'b1;
    @(negedge clk); acq_stop = 1'b0;
  endtask

  function automatic logic exp_irq(logic [15:0] c, logic tc, logic ov, logic eo,
                                   logic ne, logic hf);
    return (tc & c[11]) | (c[8] & ((c[9] ? hf : ne) | ov | eo));
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 outs", {11'd0, acq_en, irq, fifo_clr, dma_en, dma_demand}, 16'h0);
    rd(3'd0, v); check("R1 trig", v, 16'h0);
    rd(3'd5, v); check("R1 ctrl", v, 16'h0);
    rd(3'd4, v); check("R1 status", v, {6'd0, BID, 8'h00});

    // R10 live bits
    fifo_ne = 1'b1; cal_busy = 1'b1;
    rd(3'd4, v); check("R10 status live", v, {6'd0, BID, 8'h21});
    fifo_ne = 1'b0; cal_busy = 1'b0;

    // R12 trigger masking and control readback
    wr(3'd0, 16'hFFFF); rd(3'd0, v); check("R12 trig mask", v, 16'h0013);
    for (int i = 0; i < 30; i++) begin
      logic [15:0] d;
      d = 16'($urandom);
      wr(3'd5, d); rd(3'd5, v);
      check("R12 ctrl mask", v, d & 16'h1B08);
      check("R12 dma pins", {14'd0, dma_en, dma_demand}, {14'd0, d[3], d[12]});
    end
    wr(3'd5, 16'h0000);

    // R5 modes 0/1 ignore starts
    wr(3'd0, 16'h0011); wr(3'd1, 16'h1234);
    check("R5 mode1 sw start", {15'd0, acq_en}, 16'h0);
    wr(3'd0, 16'h0010);
    @(negedge clk); ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0; @(negedge clk);
    check("R5 mode0 ext start", {15'd0, acq_en}, 16'h0);

    // R4 ext disabled in mode 2
    wr(3'd0, 16'h0002);
    @(negedge clk); ext_trig = 1'b1; @(negedge clk); ext_trig = 1'b0; @(negedge clk);
    check("R4 ext disabled", {15'd0, acq_en}, 16'h0);

    // R2 software start immediate
    wr(3'd1, 16'h0000);
    check("R2 sw start", {15'd0, acq_en}, 16'h1);

    // R7 stop
    pulse_stop();
    check("R7 stop drops", {15'd0, acq_en}, 16'h0);
    rd(3'd4, v); check("R7 eoa flag", {15'd0, v[4]}, 16'h1);
    wr(3'd1, 16'h0);
    check("R7 start after done ignored", {15'd0, acq_en}, 16'h0);

    // R6 fifo reset pulse and re-arm
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd2; #1;
    check("R6 fifo_clr pulse", {15'd0, fifo_clr}, 16'h1);
    @(negedge clk); bus_wr = 1'b0; #1;
    check("R6 fifo_clr one cycle", {15'd0, fifo_clr}, 16'h0);
    rd(3'd4, v); check("R6 eoa cleared", {15'd0, v[4]}, 16'h0);

    // R4 ext enabled, mode 2
    wr(3'd0, 16'h0012);
    @(negedge clk); ext_trig = 1'b1; @(negedge clk);
    check("R4 ext start", {15'd0, acq_en}, 16'h1);
    ext_trig = 1'b0;
    wr(3'd2, 16'h0);
    check("R6 reset drops acq_en", {15'd0, acq_en}, 16'h0);

    // R3 delayed start
    wr(3'd0, 16'h0003);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd1; sample_tick = 1'b1;
    @(negedge clk); bus_wr = 1'b0; sample_tick = 1'b0;
    for (int i = 0; i < 71; i++) begin
      tick();
      if (i % 10 == 0) @(negedge clk);
    end
    check("R3 before 72nd tick", {15'd0, acq_en}, 16'h0);
    tick();
    check("R3 at 72nd tick", {15'd0, acq_en}, 16'h1);
    wr(3'd2, 16'h0);

    // R8 overflow sticky
    @(negedge clk); fifo_ovf = 1'b1; @(negedge clk); fifo_ovf = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd4, v); check("R8 ovf sticky", {15'd0, v[3]}, 16'h1);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd2; fifo_ovf = 1'b1;
    @(negedge clk); bus_wr = 1'b0; fifo_ovf = 1'b0;
    rd(3'd4, v); check("R6 reset beats ovf", {15'd0, v[3]}, 16'h0);

    // R9 terminal count, same-cycle set wins
    @(negedge clk); dma_tc = 1'b1; @(negedge clk); dma_tc = 1'b0;
    rd(3'd4, v); check("R9 tc set", {15'd0, v[7]}, 16'h1);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd3; dma_tc = 1'b1;
    @(negedge clk); bus_wr = 1'b0; dma_tc = 1'b0;
    rd(3'd4, v); check("R9 set wins", {15'd0, v[7]}, 16'h1);
    wr(3'd3, 16'h0);
    rd(3'd4, v); check("R9 tc cleared", {15'd0, v[7]}, 16'h0);

    // R11 interrupt combinations, random with reference function
    for (int i = 0; i < 40; i++) begin
      logic [15:0] c;
      logic tcf, ovf;
      c   = 16'($urandom) & 16'h0B00;
      tcf = 1'($urandom);
      ovf = 1'($urandom);
      wr(3'd5, c);
      wr(3'd2, 16'h0); wr(3'd3, 16'h0);
      if (tcf) begin @(negedge clk); dma_tc = 1'b1; @(negedge clk); dma_tc = 1'b0; end
      if (ovf) begin @(negedge clk); fifo_ovf = 1'b1; @(negedge clk); fifo_ovf = 1'b0; end
      fifo_ne = 1'($urandom); fifo_half = 1'($urandom);
      rd(3'd4, v);
      check("R11 irq", {15'd0, irq}, {15'd0, exp_irq(c, tcf, ovf, 1'b0, fifo_ne, fifo_half)});
      check("R11 pend bit", {15'd0, v[6]}, {15'd0, exp_irq(c, tcf, ovf, 1'b0, fifo_ne, fifo_half)});
    end
    fifo_ne = 1'b0; fifo_half = 1'b0;

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule